// File: doc/BRIEF.md
# Programmable Flag Threshold Loader

This block holds the two thresholds that a FIFO's partial-flag logic compares its fill level against: an almost-empty offset and an almost-full offset. Each is as wide as the FIFO address. A synchronous master reset loads both offsets with one of two preset values. The level of a select input during reset picks which value. The same reset also captures the level of a dual-purpose pin as the first-word-fall-through mode select.

After reset that dual-purpose pin becomes a serial data input. While the serial enable is high, one bit is taken on each clock edge. The almost-empty offset is filled first, least significant bit first, then the almost-full offset. The position then wraps back to the almost-empty offset. Offsets can also be written whole from a parallel bus: a load strobe together with write enable writes the bus into the almost-empty offset, and the next such strobe writes the almost-full offset, alternating from then on.

A partial reset restarts both loading sequences but keeps the offset values. Loading never touches FIFO storage or pointers, which lie outside this block. There is no back-pressure: every qualified clock edge is accepted in that same cycle.

Top module: `flag_ofs_loader`

## Requirements
- R1: At a clock edge with `mrst` high, both offsets become 0x07F (zero-extended to AW bits) if `dflt_hi` is 0, or 0x3FF if `dflt_hi` is 1.
- R2: `fwft_mode` takes the value of `mode_si` at every edge with `mrst` high and holds it at all other edges, whatever `mode_si` does.
- R3: At an edge with `ser_en` high, `mrst` and `prst` low, and no parallel write, the value of `mode_si` is written into bit k of the currently selected offset, and k then advances by one (least significant bit first).
- R4: Serial positions 0..AW-1 address the almost-empty offset and AW..2*AW-1 address the almost-full offset. After position 2*AW-1 the next bit goes to bit 0 of the almost-empty offset.
- R5: At an edge with `ld` and `wr_en` both high and no reset, `din` is written into the almost-empty offset on the first such strobe after any reset, and into the almost-full offset on the next, alternating after that.
- R6: When a parallel write and `ser_en` coincide, the parallel write wins. The serial bit is discarded and the serial position does not advance.
- R7: At an edge with `prst` high and `mrst` low, neither offset changes and neither load is performed. Both the serial position and the parallel alternation restart at the almost-empty offset.
- R8: With `ld` high and `wr_en` low, or with neither load requested, both offsets hold their values.
- R9: A serial bit changes at most one bit of one offset. All other bits of both offsets are left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write-side clock |
| mrst | input | 1 | Synchronous master reset, active high |
| prst | input | 1 | Synchronous partial reset, active high |
| dflt_hi | input | 1 | Selects 0x3FF (1) or 0x07F (0) as the reset default |
| mode_si | input | 1 | Mode select during master reset; serial data afterwards |
| ser_en | input | 1 | Serial load enable |
| ld | input | 1 | Parallel load strobe |
| wr_en | input | 1 | Write enable that qualifies the parallel strobe |
| din | input | AW | Parallel offset data |
| fwft_mode | output | 1 | Captured mode select |
| ae_ofs | output | AW | Almost-empty offset |
| af_ofs | output | AW | Almost-full offset |

## Verification
Every cycle, the assertions check four things: the serial position steps by one and wraps at 2*AW, the parallel target toggles on each parallel write, a coincident parallel write freezes the serial position, and a partial reset leaves both offsets untouched. They also check that a serial bit flips at most one offset bit, that an idle cycle holds an offset, and that the mode flag moves only under master reset. Only the bench scenarios show that bits land at the right positions of the right register, that the reset defaults match the select level, and that the empty-then-full ordering survives long random mixes of serial bits, parallel strobes and partial resets.

// File: rtl/ofs_pkg.sv
package ofs_pkg;
  typedef enum logic {
    OFS_EMPTY = 1'b0,
    OFS_FULL  = 1'b1
  } ofs_tgt_e;

  localparam int unsigned NUM_OFS = 2;

  function automatic logic [31:0] dflt_value(input logic hi);
    return hi ? 32'h0000_03FF : 32'h0000_007F;
  endfunction
endpackage

// File: rtl/ofs_ser_seq.sv
module ofs_ser_seq #(
  parameter int unsigned AW = 12,
  localparam int unsigned PW = $clog2(2 * AW),
  localparam int unsigned IW = $clog2(AW)
) (
  input  logic            clk,
  input  logic            restart,
  input  logic            go,
  output ofs_pkg::ofs_tgt_e tgt,
  output logic [IW-1:0]   idx,
  output logic [PW-1:0]   pos
);
  localparam logic [PW-1:0] LAST  = PW'(2 * AW - 1);
  localparam logic [PW-1:0] SPLIT = PW'(AW);

  logic [PW-1:0] pos_q;

  always_ff @(posedge clk) begin
    if (restart)
      pos_q <= '0;
    else if (go)
      pos_q <= (pos_q == LAST) ? '0 : pos_q + PW'(1);
  end

  always_comb begin
    pos = pos_q;
    if (pos_q >= SPLIT) begin
      tgt = ofs_pkg::OFS_FULL;
      idx = IW'(pos_q - SPLIT);
    end else begin
      tgt = ofs_pkg::OFS_EMPTY;
      idx = IW'(pos_q);
    end
  end

  AST_SER_STEP: assert property (@(posedge clk) disable iff (restart)
    (go && pos_q != LAST) |=> (pos_q == $past(pos_q) + PW'(1))); // R3
  AST_SER_WRAP: assert property (@(posedge clk) disable iff (restart)
    (go && pos_q == LAST) |=> (pos_q == '0)); // R4
endmodule

// File: rtl/ofs_par_seq.sv
module ofs_par_seq (
  input  logic              clk,
  input  logic              restart,
  input  logic              go,
  output ofs_pkg::ofs_tgt_e tgt
);
  ofs_pkg::ofs_tgt_e tgt_q;

  always_ff @(posedge clk) begin
    if (restart)
      tgt_q <= ofs_pkg::OFS_EMPTY;
    else if (go)
      tgt_q <= (tgt_q == ofs_pkg::OFS_EMPTY) ? ofs_pkg::OFS_FULL : ofs_pkg::OFS_EMPTY;
  end

  assign tgt = tgt_q;

  AST_PAR_TOGGLE: assert property (@(posedge clk) disable iff (restart)
    go |=> (tgt_q != $past(tgt_q))); // R5
endmodule

// File: rtl/ofs_reg.sv
module ofs_reg #(
  parameter int unsigned AW = 12,
  localparam int unsigned IW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          dflt_hi,
  input  logic          par_we,
  input  logic [AW-1:0] par_d,
  input  logic          ser_we,
  input  logic [IW-1:0] ser_idx,
  input  logic          ser_bit,
  output logic [AW-1:0] q
);
  logic [AW-1:0] q_r;
  logic [AW-1:0] q_n;

  always_comb begin
    q_n = q_r;
    if (mrst)
      q_n = AW'(ofs_pkg::dflt_value(dflt_hi));
    else if (par_we)
      q_n = par_d;
    else if (ser_we)
      q_n[ser_idx] = ser_bit;
  end

  always_ff @(posedge clk) q_r <= q_n;

  assign q = q_r;

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (mrst)
    (!par_we && !ser_we) |=> $stable(q_r)); // R8
  AST_ONE_BIT: assert property (@(posedge clk) disable iff (mrst)
    (ser_we && !par_we) |=> ($countones(q_r ^ $past(q_r)) <= 1)); // R9
endmodule

// File: rtl/flag_ofs_loader.sv
module flag_ofs_loader #(
  parameter int unsigned AW = 12,
  localparam int unsigned PW = $clog2(2 * AW),
  localparam int unsigned IW = $clog2(AW)
) (
  input  logic          clk,
  input  logic          mrst,
  input  logic          prst,
  input  logic          dflt_hi,
  input  logic          mode_si,
  input  logic          ser_en,
  input  logic          ld,
  input  logic          wr_en,
  input  logic [AW-1:0] din,
  output logic          fwft_mode,
  output logic [AW-1:0] ae_ofs,
  output logic [AW-1:0] af_ofs
);
  logic              restart;
  logic              par_go;
  logic              ser_go;
  ofs_pkg::ofs_tgt_e ser_tgt;
  ofs_pkg::ofs_tgt_e par_tgt;
  logic [IW-1:0]     ser_idx;
  logic [PW-1:0]     ser_pos;
  logic [AW-1:0]     ofs_q [ofs_pkg::NUM_OFS];
  logic              mode_q;

  assign restart = mrst || prst;
  assign par_go  = !restart && ld && wr_en;
  assign ser_go  = !restart && ser_en && !(ld && wr_en);

  always_ff @(posedge clk) begin
    if (mrst) mode_q <= mode_si;
  end
  assign fwft_mode = mode_q;

  ofs_ser_seq #(.AW(AW)) u_ser (
    .clk     (clk),
    .restart (restart),
    .go      (ser_go),
    .tgt     (ser_tgt),
    .idx     (ser_idx),
    .pos     (ser_pos)
  );

  ofs_par_seq u_par (
    .clk     (clk),
    .restart (restart),
    .go      (par_go),
    .tgt     (par_tgt)
  );

  for (genvar g = 0; g < ofs_pkg::NUM_OFS; g++) begin : g_ofs
    ofs_reg #(.AW(AW)) u_reg (
      .clk     (clk),
      .mrst    (mrst),
      .dflt_hi (dflt_hi),
      .par_we  (par_go && (int'(par_tgt) == g)),
      .par_d   (din),
      .ser_we  (ser_go && (int'(ser_tgt) == g)),
      .ser_idx (ser_idx),
      .ser_bit (mode_si),
      .q       (ofs_q[g])
    );
  end

  assign ae_ofs = ofs_q[0];
  assign af_ofs = ofs_q[1];

  AST_PAR_PRIO: assert property (@(posedge clk) disable iff (mrst || prst)
    (ld && wr_en && ser_en) |=> $stable(ser_pos)); // R6
  AST_PRST_KEEP: assert property (@(posedge clk) disable iff (mrst)
    prst |=> ($stable(ae_ofs) && $stable(af_ofs))); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (mrst)
    1'b1 |=> $stable(fwft_mode)); // R2
endmodule

// File: tb/tb_flag_ofs_loader.sv
module tb_flag_ofs_loader;
  localparam int unsigned AW = 12;

  logic clk = 1'b0;
  logic mrst = 1'b1, prst = 1'b0, dflt_hi = 1'b0, mode_si = 1'b0;
  logic ser_en = 1'b0, ld = 1'b0, wr_en = 1'b0;
  logic [AW-1:0] din = '0;
  logic fwft_mode;
  logic [AW-1:0] ae_ofs, af_ofs;

  int n_chk = 0;
  int n_err = 0;

  logic [AW-1:0] m_ae, m_af;
  logic m_mode;
  int m_spos;
  bit m_ptgl;

  always #2 clk = ~clk;

  flag_ofs_loader #(.AW(AW)) dut (
    .clk(clk), .mrst(mrst), .prst(prst), .dflt_hi(dflt_hi), .mode_si(mode_si),
    .ser_en(ser_en), .ld(ld), .wr_en(wr_en), .din(din),
    .fwft_mode(fwft_mode), .ae_ofs(ae_ofs), .af_ofs(af_ofs)
  );

  function automatic logic [AW-1:0] dflt(input logic hi);
    return hi ? AW'(12'h3FF) : AW'(12'h07F);
  endfunction

  // reference model, one clock edge
  task automatic model_edge();
    if (mrst) begin
      m_ae = dflt(dflt_hi); m_af = dflt(dflt_hi);
      m_mode = mode_si; m_spos = 0; m_ptgl = 1'b0;
    end else if (prst) begin
      m_spos = 0; m_ptgl = 1'b0;
    end else if (ld && wr_en) begin
      if (!m_ptgl) m_ae = din; else m_af = din;
      m_ptgl = !m_ptgl;
    end else if (ser_en) begin
      if (m_spos < AW) m_ae[m_spos] = mode_si;
      else m_af[m_spos - AW] = mode_si;
      m_spos = (m_spos == 2 * AW - 1) ? 0 : m_spos + 1;
    end
  endtask

  task automatic check(input string tag);
    n_chk++;
    if (ae_ofs !== m_ae || af_ofs !== m_af || fwft_mode !== m_mode) begin
      n_err++;
      $display("FAIL %s: ae=%h af=%h mode=%b expected ae=%h af=%h mode=%b",
               tag, ae_ofs, af_ofs, fwft_mode, m_ae, m_af, m_mode);
    end
  endtask

  // inputs are already set (after a negedge); run one edge and check
  task automatic step(input string tag);
    model_edge();
    @(negedge clk);
    check(tag);
  endtask

  task automatic idle();
    mrst = 0; prst = 0; ser_en = 0; ld = 0; wr_en = 0;
  endtask

  task automatic ser_bit(input logic b, input string tag);
    idle(); ser_en = 1; mode_si = b; step(tag);
  endtask

  task automatic par_wr(input logic [AW-1:0] d, input string tag);
    idle(); ld = 1; wr_en = 1; din = d; step(tag);
  endtask

  initial begin
    #(4 * 150000);
    n_err++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1/R2: reset low default with mode=1
    mrst = 1; dflt_hi = 0; mode_si = 1;
    step("R1 reset default low");
    // R1: reset high default with mode=0
    dflt_hi = 1; mode_si = 0;
    step("R1 reset default high");
    // R2: mode holds after reset while pin toggles
    idle(); mode_si = 1; step("R2 mode holds");
    mode_si = 0; step("R2 mode holds");
    // R8: ld without wr_en, and idle
    ld = 1; din = 12'hABC; step("R8 ld without wr_en");
    idle(); step("R8 idle hold");
    // R3/R4/R9: full serial sweep plus wrap
    for (int i = 0; i < 2 * AW; i++) ser_bit(logic'(i % 3 == 0), "R3 R4 R9 serial sweep");
    ser_bit(1'b0, "R4 serial wrap to empty bit0");
    ser_bit(1'b0, "R4 serial after wrap");
    // R5: parallel alternation
    par_wr(12'h123, "R5 parallel empty");
    par_wr(12'h456, "R5 parallel full");
    par_wr(12'h789, "R5 parallel empty again");
    // R6: coincident loads, parallel wins
    idle(); ld = 1; wr_en = 1; ser_en = 1; mode_si = 1; din = 12'hFED;
    step("R6 parallel wins");
    ser_bit(1'b1, "R6 serial position not advanced");
    // R7: partial reset keeps offsets, restarts sequences
    idle(); prst = 1; ld = 1; wr_en = 1; din = 12'h000; step("R7 partial reset keeps offsets");
    par_wr(12'h0F0, "R7 parallel restarts at empty");
    ser_bit(1'b0, "R7 serial restarts at empty bit0");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      int r;
      r = int'($urandom_range(0, 99));
      idle();
      mrst    = (r < 2);
      prst    = (r >= 2 && r < 6);
      ser_en  = $urandom_range(0, 1) == 1;
      ld      = $urandom_range(0, 3) == 0;
      wr_en   = $urandom_range(0, 1) == 1;
      mode_si = $urandom_range(0, 1) == 1;
      dflt_hi = $urandom_range(0, 1) == 1;
      din     = AW'($urandom);
      step("R1 R2 R3 R4 R5 R6 R7 R8 R9 random");
    end
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule